// File: doc/BRIEF.md
# Configurable parallel-to-serial transmitter

This block turns a parallel word from internal logic into one serial bit stream. It runs entirely on a single fast clock at the serial bit rate. A static width setting picks one of five legal frame lengths: 4, 6, 7, 8 or 10 bits. A modulo counter inside the block divides the fast clock into frames of that length. The frame boundary stands in for the slower parallel-domain clock.

Once per frame the word on the input bus goes into a holding register. This happens at a fixed early slot of the frame. A frame-boundary strobe then moves the held word into the shift register, so each frame follows the previous one with no idle bit. Only the low `width` bits of the bus are used, and the highest of them leaves first.

If the setting is not one of the legal values, the block runs as if it were 10 and raises a configuration-error flag. The flag stays set until reset.

Top module: `par_serializer`

## Requirements
- R1: While reset is asserted and after its release, `ser_out` is 0, `cfg_err` is 0 and the slot counter is 0. The first `frame_end` pulse comes `F-1` clocks after release, where F is the frame length in effect.
- R2: `frame_end` is high for exactly one clock in every F clocks, during the last slot of each frame. The legal values for `width` are 4, 6, 7, 8 and 10.
- R3: The word is sent with bit F-1 first, then in descending bit order down to bit 0, one bit per clock.
- R4: Bus bits at positions F and above have no effect on `ser_out`.
- R5: `par_in` is sampled on the clock edge that ends slot 1 of a frame. Changes to `par_in` after that edge do not affect the word sent in the next frame.
- R6: A word captured in frame n is sent during frame n+1. `ser_out` stays 0 for the whole first frame after reset.
- R7: Frames follow one another with no gap. The first bit of a word comes in the clock right after the last bit of the previous word.
- R8: Any `width` value other than 4, 6, 7, 8 or 10 makes the block behave as F=10. It also sets `cfg_err` one clock later, and `cfg_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width | input | 4 | Static frame length setting |
| par_in | input | 10 | Parallel word, low F bits used |
| ser_out | output | 1 | Serial bit stream |
| frame_end | output | 1 | High during the last slot of each frame |
| cfg_err | output | 1 | Sticky flag for an illegal width setting |

## Verification
Some properties are checked on every clock:
- the one-clock width of the frame strobe and the bound on the slot counter;
- that the first bit after each transfer is the top valid bit of the held word;
- the fallback to 10 and the sticky error flag for illegal settings.

Only the bench scenarios can show the rest. They rebuild whole words from the serial stream for each legal length. They check the one-frame latency after reset, the masking of upper bus bits, the gap-free back-to-back frames, and that changing the bus after the capture slot leaves the next word alone.

// File: rtl/par_serializer.sv
module par_serializer #(
  parameter int W        = 10,
  parameter int CAP_SLOT = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(W+1)-1:0]     width,
  input  logic [W-1:0]               par_in,
  output logic                       ser_out,
  output logic                       frame_end,
  output logic                       cfg_err
);
  localparam int CW = $clog2(W+1);

  logic          legal;
  logic [CW-1:0] eff;
  logic [CW-1:0] slot;
  logic [W-1:0]  hold_q;
  logic [W-1:0]  shift_q;

  assign legal = (width == CW'(4)) || (width == CW'(6)) || (width == CW'(7)) ||
                 (width == CW'(8)) || (width == CW'(10));
  assign eff       = legal ? width : CW'(W);
  assign frame_end = (slot == eff - 1'b1);
  assign ser_out   = shift_q[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot    <= '0;
      hold_q  <= '0;
      shift_q <= '0;
      cfg_err <= 1'b0;
    end else begin
      slot    <= frame_end ? '0 : slot + 1'b1;
      cfg_err <= cfg_err | ~legal;
      if (slot == CW'(CAP_SLOT))
        hold_q <= par_in;
      if (frame_end)
        shift_q <= hold_q << (W - int'(eff));
      else
        shift_q <= shift_q << 1;
    end
  end
endmodule

// File: rtl/par_serializer_chk.sv
module par_serializer_chk #(
  parameter int W  = 10,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] width,
  input logic          ser_out,
  input logic          frame_end,
  input logic          cfg_err,
  input logic [CW-1:0] slot,
  input logic [CW-1:0] eff,
  input logic [W-1:0]  hold_q
);
  logic bad;
  assign bad = !(width inside {CW'(4), CW'(6), CW'(7), CW'(8), CW'(10)});

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot < eff);

  // R3
  top_bit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> ser_out == $past(hold_q[eff - 1'b1]));

  // R8
  bad_cfg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> cfg_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R8
  fallback_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> eff == CW'(W));
endmodule

bind par_serializer par_serializer_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .width(width), .ser_out(ser_out),
  .frame_end(frame_end), .cfg_err(cfg_err), .slot(slot), .eff(eff),
  .hold_q(hold_q)
);

// File: tb/par_serializer_bench.sv
module par_serializer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] width = 4'd10;
  logic [9:0] par_in = '0;
  logic       ser_out, frame_end, cfg_err;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_serializer u_par_serializer (
    .clk(clk), .rst_n(rst_n), .width(width), .par_in(par_in),
    .ser_out(ser_out), .frame_end(frame_end), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one scenario: reset, first frame, then back-to-back words.
  task automatic run_len(input logic [3:0] code, input int nwords);
    int   f    = (code inside {4, 6, 7, 8, 10}) ? int'(code) : 10;
    logic bad  = !(code inside {4, 6, 7, 8, 10});
    logic [9:0] mask = 10'((1 << f) - 1);
    logic [9:0] cur, prev;
    int   gap;
    @(negedge clk);
    width  = code;
    rst_n  = 1'b0;
    cur    = 10'($urandom);
    par_in = cur;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1 ser_out in reset", ser_out, 0);
    check("R1 cfg_err in reset", cfg_err, 0);
    rst_n = 1'b1;
    gap = 0;
    while (!frame_end) begin
      // R6: nothing sent in the first frame
      check("R6 idle first frame", ser_out, 0);
      @(negedge clk);
      gap++;
    end
    // R1: first strobe after F-1 clocks
    check("R1 first strobe", gap, f - 1);
    for (int i = 0; i < nwords; i++) begin
      logic [9:0] got = '0;
      prev   = cur;
      cur    = 10'($urandom);
      par_in = cur;
      for (int b = 0; b < f; b++) begin
        @(negedge clk);
        got = {got[8:0], ser_out};
        // R2: strobe only in the last slot
        if (frame_end != (b == f - 1))
          check("R2 strobe slot", frame_end, b == f - 1);
        // R5: bus changes after the capture edge are ignored
        if (b == 2) par_in = ~cur;
      end
      // R3 R4 R7: rebuilt word matches masked reference, no gap
      check("R3/R4/R7 word", got, prev & mask);
      check("R8 cfg_err", cfg_err, bad);
    end
  endtask

  initial begin
    run_len(4'd4, 12);
    run_len(4'd6, 12);
    run_len(4'd7, 12);
    run_len(4'd8, 12);
    run_len(4'd10, 12);
    run_len(4'd5, 6);
    run_len(4'd0, 6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule